// File: doc/BRIEF.md
# Clock Mode Transition Sequencer

This block steps a clock generator between eight operating modes. These are two FLL-engaged modes, two bypass modes, two low-power bypass modes and two PLL modes. The oscillators, the FLL, the PLL and their dividers sit outside the block. The sequencer only drives their control bits and watches their status lines.

A client asks for a target mode with a one-cycle request. The sequencer looks up the next legal intermediate mode for the pair (current, target). It applies that mode's control writes in a fixed order and waits on the status lines the mode needs. Only then does it commit the mode as current. It repeats this until the current mode equals the target.

A second kind of request is a recovery walk. It starts from whatever control state is in force, backs out of low-power and PLL use, sets the FLL factor to its minimum and settles in the internal FLL mode. Every status wait is guarded by a cycle-count timeout. On expiry the walk stops with an error and the last committed mode is kept.

Top module: `clkmode_seq`

## Requirements
- R1: After reset the current mode is 0 (internal-reference FLL) and busy, done and err are low. The controls are clock select 0, internal reference 1, low-power 0, PLL select 0, oscillator enable 0 and minimum FLL factor 0.
- R2: Modes are encoded 0 to 7 in this order: int-FLL, ext-FLL, int-bypass, ext-bypass, int-lowpower, ext-lowpower, PLL-bypass, PLL-engaged. Each committed mode must be the next hop for (previous mode, target):
  - from 0 or 1 the row is {0,1,2,3,2,3,3,3}
  - from 2 the row is {0,1,2,3,4,3,3,3}
  - from 3 the row is {0,1,2,3,2,5,6,6}
  - from 4 the row is {2,2,2,2,4,2,2,2}
  - from 5 the row is {3,3,3,3,3,5,6,6}
  - from 6 the row is {3,3,3,3,3,5,6,7}
  - from 7 the row is {6,6,6,6,6,6,6,7}
- R3: A normal request with a target code of 8 or more produces a one-cycle err pulse. busy stays low and the current mode does not change.
- R4: A request whose target equals the current mode still runs one full hop, which reapplies that mode's control writes (for example the oscillator enable).
- R5: The int-FLL hop drives clock select 0, the internal reference and low-power 0. It commits only after the internal reference status is seen and then clock status 0. The int-bypass hop drives clock select 1 with the same reference and low-power settings. It commits after clock status 1 and the internal reference status.
- R6: The ext-FLL and ext-bypass hops copy the osc_en input, captured when the request is accepted, to the oscillator enable. When that is 1, they wait for oscillator ready. They then select the external reference and drive clock select 0 or 2, and wait for the matching clock status. The ext-bypass hop also clears low-power and then clears the PLL select.
- R7: The low-power hops set low-power and clear the PLL select in the same cycle, without waiting. Low-power and PLL select are never both 1.
- R8: The PLL-bypass hop clears low-power and drives clock select 2, then waits for clock status 2. It then sets the PLL select and waits for the PLL-select status, then waits for PLL lock, and only then commits.
- R9: The PLL-engaged hop drives clock select 0 and commits only after clock status 3, which means PLL output.
- R10: A recovery request runs these steps in order:
  - clear low-power
  - if the PLL select is 1 and clock select is 0, drive clock select 2 and wait for status 2
  - if the PLL select is 1, clear it and wait for its status to clear
  - set the minimum-FLL-factor output and run the int-FLL hop
  The walk ends in mode 0 with done. The minimum-FLL-factor output stays 1 until the next accepted normal request.
- R11: busy is high from acceptance until completion. Requests that arrive while busy are ignored. done is a single-cycle pulse when the current mode reaches the target.
- R12: If a status wait lasts TIMEOUT_CYC cycles, the walk aborts with a one-cycle err pulse and returns to idle. The current mode keeps its last committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_safe | input | 1 | With req_valid: run the recovery walk instead of a mode change |
| req_mode | input | 4 | Target mode code; 8 to 15 are rejected |
| osc_en | input | 1 | Oscillator use for external hops, captured with the request |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: target reached |
| err | output | 1 | One-cycle pulse: request rejected or wait timed out |
| cur_mode | output | 3 | Last committed mode |
| ctl_clk_sel | output | 2 | Output clock select: 0 FLL/PLL, 1 internal ref, 2 external ref |
| ctl_ref_int | output | 1 | FLL reference select, 1 = internal |
| ctl_lowpwr | output | 1 | Low-power bit (FLL/PLL disabled in bypass) |
| ctl_pll_sel | output | 1 | PLL select |
| ctl_osc_on | output | 1 | Oscillator enable |
| ctl_fll_min | output | 1 | Force the minimum FLL factor |
| st_clk_sel | input | 2 | Selected clock status, 3 = PLL output |
| st_ref_int | input | 1 | Reference status, 1 = internal |
| st_pll_sel | input | 1 | PLL-select status |
| st_pll_lock | input | 1 | PLL lock status |
| st_osc_rdy | input | 1 | Oscillator ready status |

## Verification
A wrong route or a corrupt current-mode register shows at the next commit, when cur_mode moves to a mode that is not the next hop for the previous mode and target. That is within one hop of the fault. A wrong control write or a skipped wait shows as a commit while a status line still disagrees with the step's condition, or as a control combination at completion that does not belong to the target mode. A stuck wait or lost commit shows as busy never falling, and the timeout bounds that to TIMEOUT_CYC cycles before err.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 1 << MODE_W;
  localparam int REQ_W     = MODE_W + 1;
  localparam int CSEL_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    M_FLL_INT = 3'd0,
    M_FLL_EXT = 3'd1,
    M_BYP_INT = 3'd2,
    M_BYP_EXT = 3'd3,
    M_LP_INT  = 3'd4,
    M_LP_EXT  = 3'd5,
    M_PLL_BYP = 3'd6,
    M_PLL_ENG = 3'd7
  } mode_e;

  // clock select / status codes
  localparam logic [CSEL_W-1:0] CS_LOOP = 2'd0;
  localparam logic [CSEL_W-1:0] CS_IREF = 2'd1;
  localparam logic [CSEL_W-1:0] CS_EREF = 2'd2;
  localparam logic [CSEL_W-1:0] CS_PLL  = 2'd3;

  // next legal intermediate mode on the way from c to t
  function automatic mode_e next_hop(mode_e c, mode_e t);
    mode_e r;
    r = t;
    unique case (c)
      M_FLL_INT, M_FLL_EXT: begin
        if (t == M_LP_INT)      r = M_BYP_INT;
        else if (t > M_LP_INT)  r = M_BYP_EXT;
      end
      M_BYP_INT: if (t > M_LP_INT) r = M_BYP_EXT;
      M_BYP_EXT: begin
        if (t == M_LP_INT)       r = M_BYP_INT;
        else if (t == M_PLL_ENG) r = M_PLL_BYP;
      end
      M_LP_INT:  r = (t == M_LP_INT) ? M_LP_INT : M_BYP_INT;
      M_LP_EXT: begin
        if (t <= M_LP_INT)       r = M_BYP_EXT;
        else if (t == M_PLL_ENG) r = M_PLL_BYP;
      end
      M_PLL_BYP: if (t <= M_LP_INT) r = M_BYP_EXT;
      M_PLL_ENG: r = (t == M_PLL_ENG) ? M_PLL_ENG : M_PLL_BYP;
      default:   r = t;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkmode_route.sv
module clkmode_route
  import clkmode_pkg::*;
(
  input  mode_e cur,
  input  mode_e tgt,
  output mode_e hop
);
  always_comb hop = next_hop(cur, tgt);
endmodule

// File: rtl/clkmode_timer.sv
module clkmode_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr || !en) cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
    expired = en && (cnt_q == CW'(LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
  import clkmode_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_safe,
  input  logic [REQ_W-1:0]  req_mode,
  input  logic              osc_en,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [MODE_W-1:0] cur_mode,
  output logic [CSEL_W-1:0] ctl_clk_sel,
  output logic              ctl_ref_int,
  output logic              ctl_lowpwr,
  output logic              ctl_pll_sel,
  output logic              ctl_osc_on,
  output logic              ctl_fll_min,
  input  logic [CSEL_W-1:0] st_clk_sel,
  input  logic              st_ref_int,
  input  logic              st_pll_sel,
  input  logic              st_pll_lock,
  input  logic              st_osc_rdy
);

  typedef enum logic [3:0] {
    S_IDLE, S_APPLY, S_W_OSC, S_EXT, S_W_IREF, S_W_CLK, S_W_PLLS, S_W_LOCK,
    S_SF_LP, S_SF_PLL, S_SF_ENTER
  } state_e;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  state_e              state_q, state_d;
  mode_e               cur_q, cur_d, tgt_q, tgt_d, hop_q, hop_d, hop_w, commit_mode;
  logic                safe_q, safe_d, osce_q, osce_d;
  logic [CSEL_W-1:0]   exp_q, exp_d, csel_q, csel_d;
  logic                refi_q, refi_d, lp_q, lp_d, plls_q, plls_d;
  logic                oscon_q, oscon_d, fmin_q, fmin_d;
  logic                done_q, done_d, err_q, err_d;
  logic                waiting, met, expired, commit, tmr_clr;

  clkmode_route i_route (
    .cur (cur_q),
    .tgt (tgt_q),
    .hop (hop_w)
  );

  // status condition of the current wait state
  always_comb begin
    waiting = 1'b1;
    met     = 1'b0;
    unique case (state_q)
      S_W_OSC:  met = st_osc_rdy;
      S_W_IREF: met = st_ref_int;
      S_W_CLK:  met = (st_clk_sel == exp_q);
      S_W_PLLS: met = (st_pll_sel == plls_q);
      S_W_LOCK: met = st_pll_lock;
      default:  waiting = 1'b0;
    endcase
  end

  clkmode_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
    .clk     (clk),
    .rst_n   (rst_ni),
    .en      (waiting && !met),
    .clr     (tmr_clr),
    .expired (expired)
  );

  always_comb begin
    state_d = state_q;  cur_d  = cur_q;   tgt_d  = tgt_q;   hop_d  = hop_q;
    safe_d  = safe_q;   osce_d = osce_q;  exp_d  = exp_q;   csel_d = csel_q;
    refi_d  = refi_q;   lp_d   = lp_q;    plls_d = plls_q;  oscon_d = oscon_q;
    fmin_d  = fmin_q;   done_d = 1'b0;    err_d  = 1'b0;
    commit  = 1'b0;     commit_mode = hop_q;

    unique case (state_q)
      S_IDLE: if (req_valid) begin
        if (req_safe) begin
          safe_d  = 1'b1;
          state_d = S_SF_LP;
        end else if (req_mode > REQ_W'(NUM_MODES - 1)) begin
          err_d = 1'b1;
        end else begin
          tgt_d   = mode_e'(req_mode[MODE_W-1:0]);
          osce_d  = osc_en;
          fmin_d  = 1'b0;
          state_d = S_APPLY;
        end
      end
      S_APPLY: begin
        hop_d = hop_w;
        unique case (hop_w)
          M_FLL_INT: begin
            csel_d = CS_LOOP; refi_d = 1'b1; lp_d = 1'b0; exp_d = CS_LOOP;
            state_d = S_W_IREF;
          end
          M_BYP_INT: begin
            csel_d = CS_IREF; refi_d = 1'b1; lp_d = 1'b0; exp_d = CS_IREF;
            state_d = S_W_CLK;
          end
          M_FLL_EXT, M_BYP_EXT: begin
            oscon_d = osce_q;
            state_d = osce_q ? S_W_OSC : S_EXT;
          end
          M_LP_INT, M_LP_EXT: begin
            lp_d = 1'b1; plls_d = 1'b0;
            commit = 1'b1; commit_mode = hop_w;
          end
          M_PLL_BYP: begin
            lp_d = 1'b0; csel_d = CS_EREF; exp_d = CS_EREF;
            state_d = S_W_CLK;
          end
          default: begin
            csel_d = CS_LOOP; exp_d = CS_PLL;
            state_d = S_W_CLK;
          end
        endcase
      end
      S_W_OSC: if (met) state_d = S_EXT;
      S_EXT: begin
        refi_d = 1'b0;
        if (hop_q == M_FLL_EXT) begin
          csel_d = CS_LOOP; exp_d = CS_LOOP;
        end else begin
          csel_d = CS_EREF; exp_d = CS_EREF; lp_d = 1'b0;
        end
        state_d = S_W_CLK;
      end
      S_W_IREF: if (met) begin
        if (hop_q == M_FLL_INT) state_d = S_W_CLK;
        else                    commit  = 1'b1;
      end
      S_W_CLK: if (met) begin
        if (safe_q) begin
          state_d = S_SF_PLL;
        end else begin
          unique case (hop_q)
            M_BYP_INT: state_d = S_W_IREF;
            M_BYP_EXT: begin plls_d = 1'b0; commit = 1'b1; end
            M_PLL_BYP: begin plls_d = 1'b1; state_d = S_W_PLLS; end
            default:   commit = 1'b1;
          endcase
        end
      end
      S_W_PLLS: if (met) state_d = safe_q ? S_SF_ENTER : S_W_LOCK;
      S_W_LOCK: if (met) commit = 1'b1;
      S_SF_LP: begin
        lp_d = 1'b0;
        if (plls_q && (csel_q == CS_LOOP)) begin
          csel_d = CS_EREF; exp_d = CS_EREF; state_d = S_W_CLK;
        end else if (plls_q) begin
          state_d = S_SF_PLL;
        end else begin
          state_d = S_SF_ENTER;
        end
      end
      S_SF_PLL: begin
        plls_d  = 1'b0;
        state_d = S_W_PLLS;
      end
      S_SF_ENTER: begin
        fmin_d = 1'b1; safe_d = 1'b0;
        tgt_d  = M_FLL_INT; hop_d = M_FLL_INT;
        csel_d = CS_LOOP; refi_d = 1'b1; lp_d = 1'b0; exp_d = CS_LOOP;
        state_d = S_W_IREF;
      end
      default: state_d = S_IDLE;
    endcase

    if (waiting && expired) begin
      state_d = S_IDLE;
      err_d   = 1'b1;
      safe_d  = 1'b0;
    end

    if (commit) begin
      cur_d = commit_mode;
      if (commit_mode == tgt_q) begin
        state_d = S_IDLE;
        done_d  = 1'b1;
      end else begin
        state_d = S_APPLY;
      end
    end

    tmr_clr = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;    cur_q  <= M_FLL_INT; tgt_q  <= M_FLL_INT; hop_q <= M_FLL_INT;
      safe_q  <= 1'b0;      osce_q <= 1'b0;      exp_q  <= CS_LOOP;   csel_q <= CS_LOOP;
      refi_q  <= 1'b1;      lp_q   <= 1'b0;      plls_q <= 1'b0;      oscon_q <= 1'b0;
      fmin_q  <= 1'b0;      done_q <= 1'b0;      err_q  <= 1'b0;
    end else begin
      state_q <= state_d;   cur_q  <= cur_d;     tgt_q  <= tgt_d;     hop_q <= hop_d;
      safe_q  <= safe_d;    osce_q <= osce_d;    exp_q  <= exp_d;     csel_q <= csel_d;
      refi_q  <= refi_d;    lp_q   <= lp_d;      plls_q <= plls_d;    oscon_q <= oscon_d;
      fmin_q  <= fmin_d;    done_q <= done_d;    err_q  <= err_d;
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign cur_mode    = cur_q;
  assign ctl_clk_sel = csel_q;
  assign ctl_ref_int = refi_q;
  assign ctl_lowpwr  = lp_q;
  assign ctl_pll_sel = plls_q;
  assign ctl_osc_on  = oscon_q;
  assign ctl_fll_min = fmin_q;

endmodule

// File: rtl/clkmode_seq_chk.sv
module clkmode_seq_chk
  import clkmode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_safe,
  input logic [REQ_W-1:0]  req_mode,
  input logic              osc_en,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [MODE_W-1:0] cur_mode,
  input logic [CSEL_W-1:0] ctl_clk_sel,
  input logic              ctl_ref_int,
  input logic              ctl_lowpwr,
  input logic              ctl_pll_sel,
  input logic              ctl_osc_on,
  input logic              ctl_fll_min,
  input logic [CSEL_W-1:0] st_clk_sel,
  input logic              st_ref_int,
  input logic              st_pll_sel,
  input logic              st_pll_lock,
  input logic              st_osc_rdy
);

  a_r3_reject_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_safe && req_mode[MODE_W]) |=> (err && !busy));

  a_r5_int_fll_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != $past(cur_mode) && cur_mode == 3'd0) |-> ($past(st_ref_int) && $past(st_clk_sel) == 2'd0));

  a_r6_osc_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != $past(cur_mode) && (cur_mode == 3'd1 || cur_mode == 3'd3) && ctl_osc_on) |-> $past(st_osc_rdy));

  a_r7_lp_pll_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_lowpwr && ctl_pll_sel));

  a_r8_pll_byp_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != $past(cur_mode) && cur_mode == 3'd6) |-> ($past(st_pll_lock) && $past(st_pll_sel)));

  a_r9_pll_eng_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != $past(cur_mode) && cur_mode == 3'd7) |-> ($past(st_clk_sel) == 2'd3));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_keep_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (err && $past(busy)) |-> (cur_mode == $past(cur_mode)));

endmodule

bind clkmode_seq clkmode_seq_chk i_chk (.*);

// File: tb/test_clkmode_seq.sv
module test_clkmode_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 32;

  logic       clk, rst_n, req_valid, req_safe, osc_en;
  logic [3:0] req_mode;
  logic       busy, done, err, ctl_ref_int, ctl_lowpwr, ctl_pll_sel, ctl_osc_on, ctl_fll_min;
  logic [2:0] cur_mode;
  logic [1:0] ctl_clk_sel, st_clk_sel;
  logic       st_ref_int, st_pll_sel, st_pll_lock, st_osc_rdy;
  logic       stuck_lock;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  clkmode_seq #(.TIMEOUT_CYC(TMO)) i_clkmode_seq (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // plant model: each status follows its control after a random delay
  always @(negedge clk) begin
    logic [1:0] want_clk;
    want_clk = (ctl_clk_sel == 2'd0 && ctl_pll_sel) ? 2'd3 : ctl_clk_sel;
    if (st_clk_sel != want_clk && $urandom % 2) st_clk_sel = want_clk;
    if (st_ref_int != ctl_ref_int && $urandom % 2) st_ref_int = ctl_ref_int;
    if (st_pll_sel != ctl_pll_sel && $urandom % 2) st_pll_sel = ctl_pll_sel;
    if (st_osc_rdy != ctl_osc_on && $urandom % 2) st_osc_rdy = ctl_osc_on;
    if (st_pll_lock != (st_pll_sel && !stuck_lock) && $urandom % 2)
      st_pll_lock = st_pll_sel && !stuck_lock;
  end

  function automatic int exp_hop(int c, int t);
    logic [23:0] row;
    case (c)
      0, 1:    row = {3'd3, 3'd3, 3'd3, 3'd2, 3'd3, 3'd2, 3'd1, 3'd0};
      2:       row = {3'd3, 3'd3, 3'd3, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
      3:       row = {3'd6, 3'd6, 3'd5, 3'd2, 3'd3, 3'd2, 3'd1, 3'd0};
      4:       row = {3'd2, 3'd2, 3'd2, 3'd4, 3'd2, 3'd2, 3'd2, 3'd2};
      5:       row = {3'd6, 3'd6, 3'd5, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3};
      6:       row = {3'd7, 3'd6, 3'd5, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3};
      default: row = {3'd7, 3'd6, 3'd6, 3'd6, 3'd6, 3'd6, 3'd6, 3'd6};
    endcase
    return int'(row[3*t +: 3]);
  endfunction

  // {clk_sel, ref_int, lowpwr, pll_sel} at the end of a walk into mode m
  function automatic int exp_ctl(int m);
    case (m)
      0:       return {2'd0, 1'b1, 1'b0, 1'b0};
      1:       return {2'd0, 1'b0, 1'b0, 1'b0};
      2:       return {2'd1, 1'b1, 1'b0, 1'b0};
      3:       return {2'd2, 1'b0, 1'b0, 1'b0};
      4:       return {2'd1, 1'b1, 1'b1, 1'b0};
      5:       return {2'd2, 1'b0, 1'b1, 1'b0};
      6:       return {2'd2, 1'b0, 1'b0, 1'b1};
      default: return {2'd0, 1'b0, 1'b0, 1'b1};
    endcase
  endfunction

  function automatic int ctl_now();
    return int'({ctl_clk_sel, ctl_ref_int, ctl_lowpwr, ctl_pll_sel});
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input int m, input bit safe, input bit oe, input bit junk,
                        output bit gd, output bit ge, output bit sb);
    int prev;
    int e;
    prev = int'(cur_mode);
    gd = 0; ge = 0; sb = 0;
    @(negedge clk);
    req_valid = 1'b1; req_safe = safe; req_mode = 4'(m); osc_en = oe;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && !gd && !ge; i++) begin
      if (busy) sb = 1;
      if (int'(cur_mode) != prev) begin
        e = safe ? 0 : exp_hop(prev, m);
        chk(int'(cur_mode) == e, "R2 next hop", int'(cur_mode), e);
        prev = int'(cur_mode);
      end
      if (done) gd = 1;
      if (err)  ge = 1;
      if (!gd && !ge) begin
        if (junk && busy && ($urandom % 3 == 0)) begin
          req_valid = 1'b1; req_safe = 1'b0; req_mode = 4'($urandom % 16);
        end
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    if (gd) begin
      @(negedge clk);
      chk(!done, "R11 done single cycle", int'(done), 0);
    end
  endtask

  task automatic walk_ok(input int m, input bit oe, input bit junk, input string tag);
    bit gd, ge, sb;
    do_req(m, 1'b0, oe, junk, gd, ge, sb);
    chk(gd && sb && !ge, {tag, " completes with done"}, int'(gd), 1);
    chk(int'(cur_mode) == m, {tag, " final mode"}, int'(cur_mode), m);
    chk(ctl_now() == exp_ctl(m), {tag, " controls"}, ctl_now(), exp_ctl(m));
    if (m == 1 || m == 3)
      chk(ctl_osc_on == oe, "R6 oscillator enable", int'(ctl_osc_on), int'(oe));
  endtask

  task automatic safe_ok(input string tag);
    bit gd, ge, sb;
    do_req(0, 1'b1, 1'b0, 1'b0, gd, ge, sb);
    chk(gd && !ge, {tag, " recovery done"}, int'(gd), 1);
    chk(cur_mode == 3'd0, {tag, " recovery mode"}, int'(cur_mode), 0);
    chk(ctl_now() == exp_ctl(0), {tag, " recovery controls"}, ctl_now(), exp_ctl(0));
    chk(ctl_fll_min, {tag, " min factor"}, int'(ctl_fll_min), 1);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    bit gd, ge, sb;
    int m, prev;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_safe = 1'b0; req_mode = '0; osc_en = 1'b0;
    stuck_lock = 1'b0;
    st_clk_sel = 2'd0; st_ref_int = 1'b1; st_pll_sel = 1'b0; st_pll_lock = 1'b0; st_osc_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(cur_mode == 3'd0 && !busy && !done && !err, "R1 reset status", int'(cur_mode), 0);
    chk(ctl_now() == exp_ctl(0) && !ctl_osc_on && !ctl_fll_min, "R1 reset controls", ctl_now(), exp_ctl(0));

    // R4 same-mode request still runs a hop
    walk_ok(0, 1'b0, 1'b0, "R4 same mode");

    // R3 out-of-range target
    do_req(9, 1'b0, 1'b0, 1'b0, gd, ge, sb);
    chk(ge && !sb && !gd, "R3 reject", int'(ge), 1);
    chk(cur_mode == 3'd0, "R3 mode unchanged", int'(cur_mode), 0);

    // R6 oscillator use, then R4 reapply with oscillator off
    walk_ok(1, 1'b1, 1'b0, "R6 ext fll");
    walk_ok(1, 1'b0, 1'b0, "R4 reapply");
    walk_ok(3, 1'b1, 1'b0, "R6 ext bypass");

    // R8 and R9: PLL modes, then R10 recovery from PLL-engaged
    walk_ok(6, 1'b1, 1'b0, "R8 pll bypass");
    walk_ok(7, 1'b1, 1'b1, "R9 pll engaged");
    safe_ok("R10 from pll");

    // R7 low-power modes, R5 int bypass
    walk_ok(2, 1'b0, 1'b0, "R5 int bypass");
    walk_ok(4, 1'b0, 1'b0, "R7 int lowpower");
    safe_ok("R10 from lowpower");
    walk_ok(5, 1'b1, 1'b0, "R7 ext lowpower");
    walk_ok(0, 1'b1, 1'b0, "R5 int fll");

    // R12 timeout on PLL lock
    stuck_lock = 1'b1;
    do_req(7, 1'b0, 1'b1, 1'b0, gd, ge, sb);
    chk(ge && !gd, "R12 timeout err", int'(ge), 1);
    chk(cur_mode == 3'd3, "R12 last committed mode", int'(cur_mode), 3);
    @(negedge clk);
    chk(!busy && !err, "R12 back to idle", int'(busy), 0);
    stuck_lock = 1'b0;
    safe_ok("R10 after timeout");

    // random walks with ignored requests while busy
    for (int k = 0; k < 60; k++) begin
      m = $urandom % 10;
      if (m >= 8) begin
        prev = int'(cur_mode);
        m = 8 + ($urandom % 8);
        do_req(m, 1'b0, 1'b0, 1'b0, gd, ge, sb);
        chk(ge && !sb, "R3 random reject", int'(ge), 1);
        chk(int'(cur_mode) == prev, "R3 random mode kept", int'(cur_mode), prev);
      end else begin
        walk_ok(m, 1'($urandom % 2), 1'b1, "R11 random walk");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule